// File: doc/BRIEF.md
# Bus-Coupled Event and Condition Sequencer

This block is a synchronous controller that hangs off an 8-bit processor bus and steps through a small flattened state machine. Software feeds it event codes by writing through a chip-selected write strobe. It sets guard flags through a separate register bank. Once per control cycle the sequencer looks at its one-hot state, the pending event code and a snapshot of the guard flags, and takes at most one transition.

When a transition carries a non-zero action code, the sequencer places that code on its read-data lines, raises data-valid and an interrupt, and freezes. Its reply is the next bus write: that write clears the interrupt and supplies the next event, which may be the null event.

The built-in example machine has an idle state, a fault state and a concurrent run region. The run region has two independent two-state halves, A and B, expanded into four product states.

Top module: `evc_controller`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state goes to idle (`state_vec` = 6'b000001), the guard flags clear, and `irq`, `data_valid` and `bus_rdata` go to zero. The state encoding is one bit per state: idle bit 0, A0B0 bit 1, A0B1 bit 2, A1B0 bit 3, A1B1 bit 4, fault bit 5.
- R2: An event written with `bus_cs` and `bus_we` high at edge E is evaluated at edge E+1 and is used for that one cycle only.
- R3: A write with `cond_we` stores `cond_wdata` in the guard flags, which appear on `cond_level` after that edge. They hold until rewritten. Flag bits: 0 enable, 1 arm, 2 hold, 3 alarm, 4 done, 5 recover, 6 B-lock, 7 force.
- R4: The transition logic sees a guard change one cycle later than `cond_level` does. A change made while the interrupt is pending is not seen by the cycle that consumes the reply event; the cycle after it sees the change.
- R5: Event TICK_A (code 3) moves half A from A0 to A1 only when arm=1 and hold=0, and moves it from A1 to A0 unconditionally. Event TICK_B (code 4) moves half B from B0 to B1 when B-lock=0, and from B1 to B0 with no action.
- R6: With the null event (code 0) or no pending event, only condition-guarded rules fire. From idle: alarm leads to fault (action 0xE0). From A1B1: done leads to idle (action 0x50). From fault: not alarm and (recover or force) leads to idle (action 0x60).
- R7: A transition with a non-zero action drives that code on `bus_rdata` and raises `data_valid` and `irq` in the same cycle.
- R8: A transition whose action is 0 changes state without raising `irq`.
- R9: While `irq` is high the state does not change. A bus write clears `irq` and `data_valid` at its edge and is consumed at the next edge.
- R10: START (code 1) with enable=1 from idle enters A0B0 in one step (action 0x11). STOP (code 2) from any run product state returns to idle (action 0x20). ABORT (code 5) from any run product state goes to fault (action 0xE1). The half-A actions are 0x31 (to A1) and 0x30 (to A0); the B0-to-B1 action is 0x40.
- R11: Exactly one state bit is set at all times.
- R12: Event codes with no rule in the current state, including every event while in fault, cause no transition and no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs | input | 1 | Chip select for event writes |
| bus_we | input | 1 | Write strobe for event writes |
| bus_wdata | input | 8 | Event code written by software |
| cond_we | input | 1 | Write strobe for the guard flag bank |
| cond_wdata | input | 8 | New guard flag values |
| bus_rdata | output | 8 | Action code while valid, else zero |
| data_valid | output | 1 | Action code on `bus_rdata` is valid |
| irq | output | 1 | Interrupt request to the processor |
| cond_level | output | 8 | Current guard flag latch outputs |
| state_vec | output | 6 | One-hot controller state |

## Verification
The machine is driven with event-only steps (START, TICK_B, STOP), condition-only steps under the null event (alarm, done, recover), and mixed steps where a guard decides whether an event fires (TICK_A with arm and hold). These separate the trigger path from the condition path and expose any mix-up of their priority. Guard writes are placed both while the interrupt is pending and while the sequencer runs, which tells a correct one-cycle snapshot apart from a direct or a stale use of the flags. Replies with STOP and ABORT check that a whole product state is left in one step. An undefined code, events sent while in fault, and the silent B1-to-B0 step check that nothing happens when no action is due.

// File: rtl/evc_pkg.sv
// Shared constants for the event/condition sequencer: state indices,
// event codes, guard flag positions and action codes.
package evc_pkg;
    localparam int DATA_W  = 8;
    localparam int COND_W  = 8;
    localparam int STATE_N = 6;

    // One-hot state bit positions
    localparam int S_IDLE  = 0;
    localparam int S_A0B0  = 1;
    localparam int S_A0B1  = 2;
    localparam int S_A1B0  = 3;
    localparam int S_A1B1  = 4;
    localparam int S_FAULT = 5;

    // Event codes
    localparam logic [DATA_W-1:0] EV_NULL  = 8'h00;
    localparam logic [DATA_W-1:0] EV_START = 8'h01;
    localparam logic [DATA_W-1:0] EV_STOP  = 8'h02;
    localparam logic [DATA_W-1:0] EV_TICKA = 8'h03;
    localparam logic [DATA_W-1:0] EV_TICKB = 8'h04;
    localparam logic [DATA_W-1:0] EV_ABORT = 8'h05;

    // Guard flag positions
    localparam int G_EN    = 0;
    localparam int G_ARM   = 1;
    localparam int G_HOLD  = 2;
    localparam int G_ALARM = 3;
    localparam int G_DONE  = 4;
    localparam int G_RECOV = 5;
    localparam int G_BLOCK = 6;
    localparam int G_FORCE = 7;

    // Action codes (0 = no action)
    localparam logic [DATA_W-1:0] AC_NONE   = 8'h00;
    localparam logic [DATA_W-1:0] AC_START  = 8'h11;
    localparam logic [DATA_W-1:0] AC_STOP   = 8'h20;
    localparam logic [DATA_W-1:0] AC_A_DOWN = 8'h30;
    localparam logic [DATA_W-1:0] AC_A_UP   = 8'h31;
    localparam logic [DATA_W-1:0] AC_B_UP   = 8'h40;
    localparam logic [DATA_W-1:0] AC_DONE   = 8'h50;
    localparam logic [DATA_W-1:0] AC_RECOV  = 8'h60;
    localparam logic [DATA_W-1:0] AC_ALARM  = 8'hE0;
    localparam logic [DATA_W-1:0] AC_ABORT  = 8'hE1;

    typedef logic [STATE_N-1:0] state_vec_t;
endpackage

// File: rtl/evc_cond_bank.sv
// Guard flag bank. Holds the flags software writes and a snapshot that
// the transition logic reads. Assumes the snapshot may only advance on
// cycles where the sequencer runs, so a change made while an action is
// pending reaches the logic one control cycle late.
module evc_cond_bank #(
    parameter int COND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cond_we,
    input  logic [COND_W-1:0] cond_wdata,
    output logic [COND_W-1:0] cond_q,
    output logic [COND_W-1:0] cond_snap
);
    // Flag latches: store software writes
    always_ff @(posedge clk) begin
        if (!rst_n)       cond_q <= '0;
        else if (cond_we) cond_q <= cond_wdata;
    end

    // Snapshot: copy the latches on every running cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   cond_snap <= '0;
        else if (run) cond_snap <= cond_q;
    end

    a_r3_cond_store: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |=> cond_q == $past(cond_wdata));

    a_r4_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cond_snap));
endmodule

// File: rtl/evc_bus_port.sv
// Bus side of the sequencer: captures one pending event from chip-selected
// writes, and runs the action/interrupt handshake. Assumes a single event
// slot; a write always replaces the slot and releases a pending interrupt.
module evc_bus_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              act_fire,
    input  logic [DATA_W-1:0] act_code,
    output logic [DATA_W-1:0] trig_eff,
    output logic              run,
    output logic              irq,
    output logic              data_valid,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-1:0] NULL_CODE = '0;

    logic              wr;
    logic              trig_vld;
    logic [DATA_W-1:0] trig_q;
    logic [DATA_W-1:0] act_q;

    assign wr  = bus_cs & bus_we;
    assign run = ~irq;

    // Event slot: load on write, drop once a running cycle consumes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q   <= NULL_CODE;
            trig_vld <= 1'b0;
        end else if (wr) begin
            trig_q   <= bus_wdata;
            trig_vld <= 1'b1;
        end else if (run) begin
            trig_vld <= 1'b0;
        end
    end

    // Effective event: the null code when the slot is empty
    always_comb trig_eff = trig_vld ? trig_q : NULL_CODE;

    // Handshake: raise on an issued action, release on the reply write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            data_valid <= 1'b0;
            act_q      <= NULL_CODE;
        end else if (act_fire) begin
            irq        <= 1'b1;
            data_valid <= 1'b1;
            act_q      <= act_code;
        end else if (wr) begin
            irq        <= 1'b0;
            data_valid <= 1'b0;
        end
    end

    // Read data: the action code only while it is valid
    always_comb bus_rdata = data_valid ? act_q : NULL_CODE;

    a_r7_code_nonnull: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> bus_rdata != NULL_CODE);

    a_r9_reply_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq && wr |=> !irq && !data_valid);

    a_r2_consumed_once: assert property (@(posedge clk) disable iff (!rst_n)
        run && !wr |=> trig_eff == NULL_CODE);
endmodule

// File: rtl/evc_state_table.sv
// Flattened example machine. Idle and fault are plain states; the run
// region holds two concurrent halves (A, B) realised as four one-hot
// product states. Event rules are tried first; condition-only rules
// apply when no event rule fires. Assumes the guard snapshot is stable
// for the whole cycle.
module evc_state_table
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] trig,
    input  logic [COND_W-1:0] cond,
    output state_vec_t        state_q,
    output logic [DATA_W-1:0] act_code,
    output logic              act_fire
);
    state_vec_t nxt;
    logic       in_run;
    logic       half_a;
    logic       half_b;
    logic       taken;

    // Product state from the two half positions
    function automatic state_vec_t prod(input logic a, input logic b);
        state_vec_t v;
        v = '0;
        case ({a, b})
            2'b00:   v[S_A0B0] = 1'b1;
            2'b01:   v[S_A0B1] = 1'b1;
            2'b10:   v[S_A1B0] = 1'b1;
            default: v[S_A1B1] = 1'b1;
        endcase
        return v;
    endfunction

    function automatic state_vec_t one(input int idx);
        state_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // Region decode: which product half positions are active
    always_comb begin
        in_run = state_q[S_A0B0] | state_q[S_A0B1] | state_q[S_A1B0] | state_q[S_A1B1];
        half_a = state_q[S_A1B0] | state_q[S_A1B1];
        half_b = state_q[S_A0B1] | state_q[S_A1B1];
    end

    // Transition rules: next state and action for this cycle
    always_comb begin
        nxt      = state_q;
        act_code = AC_NONE;
        taken    = 1'b0;
        if (state_q[S_IDLE]) begin
            if (trig == EV_START && cond[G_EN]) begin
                nxt = prod(1'b0, 1'b0); act_code = AC_START; taken = 1'b1;
            end
            if (!taken && cond[G_ALARM]) begin
                nxt = one(S_FAULT); act_code = AC_ALARM;
            end
        end else if (in_run) begin
            if (trig == EV_STOP) begin
                nxt = one(S_IDLE); act_code = AC_STOP; taken = 1'b1;
            end else if (trig == EV_ABORT) begin
                nxt = one(S_FAULT); act_code = AC_ABORT; taken = 1'b1;
            end else if (trig == EV_TICKA) begin
                if (half_a) begin
                    nxt = prod(1'b0, half_b); act_code = AC_A_DOWN; taken = 1'b1;
                end else if (cond[G_ARM] && !cond[G_HOLD]) begin
                    nxt = prod(1'b1, half_b); act_code = AC_A_UP; taken = 1'b1;
                end
            end else if (trig == EV_TICKB) begin
                if (half_b) begin
                    nxt = prod(half_a, 1'b0); act_code = AC_NONE; taken = 1'b1;
                end else if (!cond[G_BLOCK]) begin
                    nxt = prod(half_a, 1'b1); act_code = AC_B_UP; taken = 1'b1;
                end
            end
            if (!taken && state_q[S_A1B1] && cond[G_DONE]) begin
                nxt = one(S_IDLE); act_code = AC_DONE;
            end
        end else begin
            if (!cond[G_ALARM] && (cond[G_RECOV] || cond[G_FORCE])) begin
                nxt = one(S_IDLE); act_code = AC_RECOV;
            end
        end
    end

    // State register: advance only on running cycles
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= one(S_IDLE);
        else if (run) state_q <= nxt;
    end

    always_comb act_fire = run && (act_code != AC_NONE);

    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(state_q));

    a_r10_stop_exits: assert property (@(posedge clk) disable iff (!rst_n)
        run && in_run && trig == EV_STOP |=> state_q[S_IDLE]);

    a_r6_null_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        run && state_q[S_IDLE] && trig == EV_NULL |=> !state_q[S_A0B0]);

    a_r12_fault_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        run && state_q[S_FAULT] && !cond[G_RECOV] && !cond[G_FORCE] |=> state_q[S_FAULT]);
endmodule

// File: rtl/evc_controller.sv
// Top of the event/condition sequencer. Joins the bus port, the guard
// flag bank and the state table. Assumes one reply write per action.
module evc_controller
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cond_we,
    input  logic [COND_W-1:0] cond_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              data_valid,
    output logic              irq,
    output logic [COND_W-1:0] cond_level,
    output logic [STATE_N-1:0] state_vec
);
    logic              run;
    logic              act_fire;
    logic [DATA_W-1:0] act_code;
    logic [DATA_W-1:0] trig_eff;
    logic [COND_W-1:0] cond_snap;

    evc_bus_port #(.DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .act_fire(act_fire), .act_code(act_code),
        .trig_eff(trig_eff), .run(run), .irq(irq),
        .data_valid(data_valid), .bus_rdata(bus_rdata)
    );

    evc_cond_bank #(.COND_W(COND_W)) u_cond (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cond_we(cond_we), .cond_wdata(cond_wdata),
        .cond_q(cond_level), .cond_snap(cond_snap)
    );

    evc_state_table u_table (
        .clk(clk), .rst_n(rst_n), .run(run),
        .trig(trig_eff), .cond(cond_snap),
        .state_q(state_vec), .act_code(act_code), .act_fire(act_fire)
    );

    a_r7_irq_with_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> data_valid && bus_rdata != '0);
endmodule

// File: tb/sim_evc_controller.sv
// Directed bench for the event/condition sequencer.
module sim_evc_controller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, cond_we = 1'b0;
    logic [7:0] bus_wdata = '0, cond_wdata = '0;
    logic [7:0] bus_rdata, cond_level;
    logic       data_valid, irq;
    logic [5:0] state_vec;

    int n_run = 0, n_fail = 0, wd = 0;

    localparam logic [5:0] ST_IDLE = 6'h01, ST_00 = 6'h02, ST_01 = 6'h04,
                           ST_10 = 6'h08, ST_11 = 6'h10, ST_FAULT = 6'h20;

    always #5 clk = ~clk;

    evc_controller u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .cond_we(cond_we), .cond_wdata(cond_wdata),
        .bus_rdata(bus_rdata), .data_valid(data_valid), .irq(irq),
        .cond_level(cond_level), .state_vec(state_vec)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ev(input logic [7:0] code);
        @(negedge clk); bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = code;
        @(negedge clk); bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_cond(input logic [7:0] v);
        @(negedge clk); cond_we = 1'b1; cond_wdata = v;
        @(negedge clk); cond_we = 1'b0;
    endtask

    // Expect an action: state, code on bus, valid and interrupt
    task automatic chk_act(input string req, input logic [5:0] st, input logic [7:0] code);
        chk({req, " state"}, state_vec, st);
        chk({req, " code"}, bus_rdata, code);
        chk({req, " irq"}, irq, 1);
        chk({req, " valid"}, data_valid, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1;
        chk("R1 state", state_vec, ST_IDLE);
        chk("R1 irq", irq, 0);
        chk("R1 valid", data_valid, 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 cond", cond_level, 0);
    endtask

    task automatic t_condition_only();
        step(3);
        chk("R6 idle stays idle under null", state_vec, ST_IDLE);
        wr_cond(8'h08);
        chk("R3 cond visible", cond_level, 8'h08);
        chk("R4 not used yet", state_vec, ST_IDLE);
        step(2);
        chk_act("R6 alarm", ST_FAULT, 8'hE0);
        step(3);
        chk("R9 held while irq", state_vec, ST_FAULT);
        wr_ev(8'h00);
        chk("R9 reply clears irq", irq, 0);
        chk("R9 reply clears valid", data_valid, 0);
        step(1);
        chk("R12 fault holds with alarm", state_vec, ST_FAULT);
        wr_cond(8'h20);
        step(2);
        chk_act("R6 recover", ST_IDLE, 8'h60);
        wr_ev(8'h00);
        chk("R3 cond persists", cond_level, 8'h20);
    endtask

    task automatic t_events();
        wr_cond(8'h21);
        step(2);
        wr_ev(8'h01);
        chk("R2 not before next edge", state_vec, ST_IDLE);
        chk("R2 no irq yet", irq, 0);
        step(1);
        chk_act("R10 start enters A0B0", ST_00, 8'h11);
        wr_ev(8'h04);
        chk("R9 write clears irq", irq, 0);
        chk("R9 state held at reply edge", state_vec, ST_00);
        step(1);
        chk_act("R5 B up", ST_01, 8'h40);
        wr_cond(8'h23);
        wr_ev(8'h03);
        step(1);
        chk("R4 stale snapshot state", state_vec, ST_01);
        chk("R4 stale snapshot irq", irq, 0);
        wr_ev(8'h03);
        step(1);
        chk_act("R5 A up with arm", ST_11, 8'h31);
        wr_ev(8'h03);
        step(1);
        chk_act("R5 A down", ST_01, 8'h30);
        wr_ev(8'h00);
        wr_cond(8'h27);
        step(2);
        wr_ev(8'h03);
        step(1);
        chk("R5 hold blocks A up", state_vec, ST_01);
        chk("R5 hold no irq", irq, 0);
        wr_cond(8'h23);
        step(2);
        wr_ev(8'h04);
        step(1);
        chk("R8 silent B down state", state_vec, ST_00);
        chk("R8 silent B down irq", irq, 0);
        wr_ev(8'h77);
        step(1);
        chk("R12 unknown code state", state_vec, ST_00);
        chk("R12 unknown code irq", irq, 0);
        wr_ev(8'h04);
        step(1);
        chk_act("R5 B up again", ST_01, 8'h40);
        wr_ev(8'h02);
        step(1);
        chk_act("R10 stop exits product", ST_IDLE, 8'h20);
        wr_ev(8'h00);
    endtask

    task automatic t_done_and_abort();
        wr_ev(8'h01);
        step(1);
        chk_act("R10 start", ST_00, 8'h11);
        wr_ev(8'h03);
        step(1);
        chk_act("R10 A half moves alone", ST_10, 8'h31);
        wr_ev(8'h04);
        step(1);
        chk_act("R10 B half moves alone", ST_11, 8'h40);
        wr_ev(8'h00);
        wr_cond(8'h13);
        step(2);
        chk_act("R6 done leaves region", ST_IDLE, 8'h50);
        wr_ev(8'h00);
        wr_ev(8'h01);
        step(1);
        chk_act("R10 start again", ST_00, 8'h11);
        wr_ev(8'h05);
        step(1);
        chk_act("R10 abort to fault", ST_FAULT, 8'hE1);
        wr_ev(8'h01);
        step(1);
        chk("R12 fault ignores event state", state_vec, ST_FAULT);
        chk("R12 fault ignores event irq", irq, 0);
        chk("R11 one-hot", $countones(state_vec), 1);
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got %0d expected below 20000", wd);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_condition_only();
        t_events();
        t_done_and_abort();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule